// File: doc/BRIEF.md
# Tagged Index-Register Address Unit

This unit forms operand effective addresses for a machine with 36-bit words and 15-bit addresses. For each accepted instruction it takes the address field Y, a 3-bit tag and a 2-bit flag. It holds a bank of seven 15-bit index registers and returns Y minus an index term C(T). The subtraction wraps modulo 2^15. Index-load instructions use the same tag decoding to pick which registers to write.

The unit has two modes. After reset it is in the legacy multi-select mode. In this mode each tag bit enables one of three registers: bit 0 enables register 1, bit 1 enables register 2 and bit 2 enables register 4. When several registers are enabled, their contents are ORed together before the subtraction. A dedicated mode-exit instruction moves the unit into the single-select mode. In that mode the tag value names one of registers 1 to 7, and a tag of 0 names none. Only a reset returns the unit to the legacy mode.

An address instruction with both flag bits set asks for one level of indirection. The unit stops accepting work and presents the first effective address as a fetch request. When the indirect word's tag and Y come back, it indexes them again to form the final address.

Top module: `tagged_index_unit`

## Requirements
- R1: After reset all index registers read as zero, the unit is in legacy mode, `in_ready` is high, and `ea_valid` and `ind_req` are low.
- R2: An address instruction (op 2'b00) with tag 0 and flag other than 2'b11 returns EA = Y.
- R3: In legacy mode, tag bit 0, bit 1 and bit 2 select index registers 1, 2 and 4, and EA = Y - C(T).
- R4: In legacy mode, a tag with several bits set uses the bitwise OR of all selected registers as C(T).
- R5: In legacy mode, an index load (op 2'b01) writes `in_load` into every register its tag selects. Registers 3, 5, 6 and 7 are never written or read in this mode.
- R6: The mode-exit instruction (op 2'b10) switches the unit to single-select mode. From then until reset, tag value t (1..7) selects register t alone and tag 0 selects none.
- R7: In single-select mode, an index load writes only the register named by the tag. With tag 0 it writes nothing.
- R8: Index load, mode exit and index control (op 2'b11) return EA = Y with no indexing. On these instructions the flag field is ignored and no indirect request is raised.
- R9: An address instruction with flag 2'b11 raises `ind_req` with `ind_addr` = Y - C(T) one cycle after acceptance. It holds `ind_req` high and `in_ready` low, ignoring `in_valid`, until `ind_valid` is seen.
- R10: When `ind_valid` is seen, the final EA is `ind_y` - C(`ind_tag`) under the current mode. Only one level of indirection is followed.
- R11: `ea_valid` pulses for one cycle. It comes in the cycle after a direct instruction is accepted, or in the cycle after `ind_valid` is seen.
- R12: The subtraction wraps modulo 2^15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction fields are valid |
| in_ready | output | 1 | Unit can accept an instruction |
| in_op | input | 2 | 00 address, 01 index load, 10 mode exit, 11 index control |
| in_y | input | 15 | Address field Y |
| in_tag | input | 3 | Tag field |
| in_flag | input | 2 | Flag field; 11 requests indirection |
| in_load | input | 15 | Value written by an index load |
| ind_req | output | 1 | Indirect word fetch request |
| ind_addr | output | 15 | Address of the indirect word |
| ind_valid | input | 1 | Indirect word fields are valid |
| ind_y | input | 15 | Y field of the indirect word |
| ind_tag | input | 3 | Tag field of the indirect word |
| ea_valid | output | 1 | Effective address is valid (one-cycle pulse) |
| ea | output | 15 | Effective address |

## Verification
The bench targets the difference between the two modes. It applies tag 3 before and after mode exit. A design that kept ORing in single-select mode would return Y minus (reg1 | reg2) instead of Y minus reg3. A design that decoded the tag as a value in legacy mode would return the wrong register. A legacy multi-bit load is followed by reads of each written register, which catches a design that writes only one of them. A single-select load with tag 0 is followed by reads of the other registers, which catches a stray write.

During an indirect wait the bench offers a load instruction. A design that did not stall would corrupt register 1. The bench also checks that the final address is indexed by the indirect word's own tag, not the first tag. A wrapping subtraction catches a design that saturates or widens the result.

// File: rtl/xau_pkg.sv
// Package: shared operation encoding for the tagged index address unit.
package xau_pkg;
    typedef enum logic [1:0] {
        XOP_ADDR = 2'b00,  // address formation, may be indirect
        XOP_LOAD = 2'b01,  // index register load
        XOP_EXIT = 2'b10,  // leave legacy multi-select mode
        XOP_CTRL = 2'b11   // other index control, EA = Y
    } xop_e;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_WAIT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/xau_tag_decode.sv
// Module: xau_tag_decode
// Turns a tag into a register select mask (bit r-1 = register r).
// Legacy mode: tag bit b selects register 2^b (several at once allowed).
// Single-select mode: tag value t selects register t, 0 selects none.
// Assumes NREG >= 2^(TAG_W-1) so every legacy bit has a register.
module xau_tag_decode #(
    parameter int TAG_W = 3,
    parameter int NREG  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             ext_mode_i,
    output logic [NREG-1:0]  sel_o
);
    // Registers reachable in legacy mode: the powers of two.
    function automatic logic [NREG-1:0] legacy_set();
        logic [NREG-1:0] m;
        m = '0;
        for (int b = 0; b < TAG_W; b++) begin
            if ((1 << b) <= NREG) m[(1 << b) - 1] = 1'b1;
        end
        return m;
    endfunction
    localparam logic [NREG-1:0] LEGACY_MASK = legacy_set();

    logic [NREG-1:0] legacy_sel;
    logic [NREG-1:0] single_sel;

    for (genvar r = 1; r <= NREG; r++) begin : g_reg
        localparam bit IS_P2 = ((r & (r - 1)) == 0);
        localparam int BIT   = $clog2(r);
        if (IS_P2 && BIT < TAG_W) begin : g_legacy
            // Purpose: legacy select from one tag bit.
            assign legacy_sel[r-1] = tag_i[BIT];
        end else begin : g_nolegacy
            assign legacy_sel[r-1] = 1'b0;
        end
        // Purpose: single select by tag value.
        assign single_sel[r-1] = (tag_i == TAG_W'(r));
    end

    // Purpose: pick the decoding of the current mode.
    assign sel_o = ext_mode_i ? single_sel : legacy_sel;

    // R6
    single_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode_i |-> $onehot0(sel_o));
    // R5
    legacy_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode_i |-> ((sel_o & ~LEGACY_MASK) == '0));
endmodule

// File: rtl/xau_regbank.sv
// Module: xau_regbank
// Bank of NREG index registers, written by mask, read as the OR of a
// select mask. Assumes at most one write per cycle; reset clears all.
module xau_regbank #(
    parameter int NREG   = 7,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREG-1:0]   wr_mask_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    input  logic [NREG-1:0]   rd_sel_i,
    output logic [ADDR_W-1:0] cterm_o
);
    logic [ADDR_W-1:0] regs_q [NREG];

    // Purpose: write every masked register with the load value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) regs_q[k] <= '0;
        end else begin
            for (int k = 0; k < NREG; k++) begin
                if (wr_mask_i[k]) regs_q[k] <= wr_data_i;
            end
        end
    end

    // Purpose: OR together all selected registers to form C(T).
    always_comb begin
        cterm_o = '0;
        for (int k = 0; k < NREG; k++) begin
            if (rd_sel_i[k]) cterm_o = cterm_o | regs_q[k];
        end
    end

    for (genvar k = 0; k < NREG; k++) begin : g_chk
        // R7
        hold_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_mask_i[k] |=> $stable(regs_q[k]));
        // R5
        load_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wr_mask_i[k] |=> (regs_q[k] == $past(wr_data_i)));
    end
endmodule

// File: rtl/xau_seq.sv
// Module: xau_seq
// Sequencer: accepts instructions, tracks the mode, chooses which tag
// and Y feed the shared index path, and registers the outputs.
// Assumes cterm_i is the index term for dec_tag_o in the same cycle.
module xau_seq
    import xau_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic [1:0]        in_op_i,
    input  logic [ADDR_W-1:0] in_y_i,
    input  logic [TAG_W-1:0]  in_tag_i,
    input  logic [1:0]        in_flag_i,
    input  logic              ind_valid_i,
    input  logic [ADDR_W-1:0] ind_y_i,
    input  logic [TAG_W-1:0]  ind_tag_i,
    input  logic [ADDR_W-1:0] cterm_i,
    output logic [TAG_W-1:0]  dec_tag_o,
    output logic              ext_mode_o,
    output logic              wr_en_o,
    output logic              ind_req_o,
    output logic [ADDR_W-1:0] ind_addr_o,
    output logic              ea_valid_o,
    output logic [ADDR_W-1:0] ea_o
);
    seq_state_e        state_q;
    xop_e              op;
    logic              accept;
    logic              go_ind;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] diff;

    // Purpose: decode the incoming instruction and the acceptance.
    assign op      = xop_e'(in_op_i);
    assign accept  = in_valid_i && (state_q == SQ_IDLE);
    assign go_ind  = (op == XOP_ADDR) && (in_flag_i == 2'b11);
    assign wr_en_o = accept && (op == XOP_LOAD);

    // Purpose: route the indirect word into the index path while waiting.
    assign dec_tag_o = (state_q == SQ_WAIT) ? ind_tag_i : in_tag_i;
    assign base      = (state_q == SQ_WAIT) ? ind_y_i : in_y_i;
    assign diff      = base - cterm_i;

    assign in_ready_o = (state_q == SQ_IDLE);
    assign ind_req_o  = (state_q == SQ_WAIT);

    // Purpose: state, mode and registered address outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SQ_IDLE;
            ext_mode_o <= 1'b0;
            ea_valid_o <= 1'b0;
            ea_o       <= '0;
            ind_addr_o <= '0;
        end else begin
            ea_valid_o <= 1'b0;
            if (state_q == SQ_IDLE) begin
                if (accept) begin
                    if (go_ind) begin
                        state_q    <= SQ_WAIT;
                        ind_addr_o <= diff;
                    end else begin
                        ea_valid_o <= 1'b1;
                        ea_o       <= (op == XOP_ADDR) ? diff : in_y_i;
                        if (op == XOP_EXIT) ext_mode_o <= 1'b1;
                    end
                end
            end else if (ind_valid_i) begin
                state_q    <= SQ_IDLE;
                ea_valid_o <= 1'b1;
                ea_o       <= diff;
            end
        end
    end

    // R6
    mode_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mode_o |=> ext_mode_o);
    // R6
    mode_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode_o ##1 ext_mode_o |-> $past(accept && op == XOP_EXIT));
    // R9
    ind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ind_req_o && !ind_valid_i |=> ind_req_o && !in_ready_o);
    // R10
    ind_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ind_req_o && ind_valid_i |=> ea_valid_o && !ind_req_o);
    // R11
    direct_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !go_ind |=> ea_valid_o);
    // R8
    ctrl_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op != XOP_ADDR |=> ea_o == $past(in_y_i) && !ind_req_o);
endmodule

// File: rtl/tagged_index_unit.sv
// Module: tagged_index_unit (top)
// Index register bank plus effective address formation with a legacy
// multi-select mode, a single-select mode and one-level indirection.
// Assumes the indirect word returns only while ind_req is high.
module tagged_index_unit #(
    parameter int ADDR_W = 15,
    parameter int TAG_W  = 3,
    parameter int NREG   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic [ADDR_W-1:0] in_y,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [1:0]        in_flag,
    input  logic [ADDR_W-1:0] in_load,
    output logic              ind_req,
    output logic [ADDR_W-1:0] ind_addr,
    input  logic              ind_valid,
    input  logic [ADDR_W-1:0] ind_y,
    input  logic [TAG_W-1:0]  ind_tag,
    output logic              ea_valid,
    output logic [ADDR_W-1:0] ea
);
    logic [TAG_W-1:0]  dec_tag;
    logic              ext_mode;
    logic              wr_en;
    logic [NREG-1:0]   sel;
    logic [NREG-1:0]   wr_mask;
    logic [ADDR_W-1:0] cterm;

    // Purpose: loads write exactly the registers the tag selects.
    assign wr_mask = wr_en ? sel : '0;

    xau_seq #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .in_valid_i(in_valid), .in_ready_o(in_ready),
        .in_op_i(in_op), .in_y_i(in_y), .in_tag_i(in_tag), .in_flag_i(in_flag),
        .ind_valid_i(ind_valid), .ind_y_i(ind_y), .ind_tag_i(ind_tag),
        .cterm_i(cterm), .dec_tag_o(dec_tag), .ext_mode_o(ext_mode),
        .wr_en_o(wr_en), .ind_req_o(ind_req), .ind_addr_o(ind_addr),
        .ea_valid_o(ea_valid), .ea_o(ea)
    );

    xau_tag_decode #(.TAG_W(TAG_W), .NREG(NREG)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .tag_i(dec_tag), .ext_mode_i(ext_mode), .sel_o(sel)
    );

    xau_regbank #(.NREG(NREG), .ADDR_W(ADDR_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_mask_i(wr_mask), .wr_data_i(in_load),
        .rd_sel_i(sel), .cterm_o(cterm)
    );

    // R11
    no_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ind_req |-> !ea_valid || $past(!ind_req));
endmodule

// File: tb/tagged_index_unit_test.sv
module tagged_index_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_op = 2'b00;
    logic [14:0] in_y = '0;
    logic [2:0]  in_tag = '0;
    logic [1:0]  in_flag = '0;
    logic [14:0] in_load = '0;
    logic        ind_req;
    logic [14:0] ind_addr;
    logic        ind_valid = 1'b0;
    logic [14:0] ind_y = '0;
    logic [2:0]  ind_tag = '0;
    logic        ea_valid;
    logic [14:0] ea;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [14:0] expq [$];
    string       reqq [$];
    logic [14:0] mreg [1:7];
    bit          mext = 1'b0;

    always #4 clk = ~clk;

    tagged_index_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_y(in_y), .in_tag(in_tag), .in_flag(in_flag),
        .in_load(in_load), .ind_req(ind_req), .ind_addr(ind_addr),
        .ind_valid(ind_valid), .ind_y(ind_y), .ind_tag(ind_tag),
        .ea_valid(ea_valid), .ea(ea)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] ct(logic [2:0] t);
        logic [14:0] v;
        v = '0;
        if (!mext) begin
            if (t[0]) v = v | mreg[1];
            if (t[1]) v = v | mreg[2];
            if (t[2]) v = v | mreg[4];
        end else if (t != 0) begin
            v = mreg[t];
        end
        return v;
    endfunction

    // Monitor: pops the expected address for every valid output.
    always @(negedge clk) begin
        if (rst_n && ea_valid) begin
            if (expq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11 actual unexpected ea_valid ea %0h expected none", ea);
            end else begin
                logic [14:0] e;
                string r;
                e = expq.pop_front();
                r = reqq.pop_front();
                chk(r, ea, e);
            end
        end
    end

    // Driver for direct instructions; updates the reference model.
    task automatic issue(logic [1:0] op, logic [14:0] y, logic [2:0] t,
                         logic [1:0] f, logic [14:0] ld, string req);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_y = y; in_tag = t; in_flag = f; in_load = ld;
        expq.push_back(op == 2'b00 ? 15'(y - ct(t)) : y);
        reqq.push_back(req);
        if (op == 2'b01) begin
            if (!mext) begin
                if (t[0]) mreg[1] = ld;
                if (t[1]) mreg[2] = ld;
                if (t[2]) mreg[4] = ld;
            end else if (t != 0) begin
                mreg[t] = ld;
            end
        end
        if (op == 2'b10) mext = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " no ind_req"}, ind_req, 0);
    endtask

    // Driver for one indirect address instruction.
    task automatic indirect(logic [14:0] y, logic [2:0] t,
                            logic [14:0] iy, logic [2:0] it);
        logic [14:0] first;
        first = y - ct(t);
        @(negedge clk);
        in_valid = 1'b1; in_op = 2'b00; in_y = y; in_tag = t; in_flag = 2'b11;
        expq.push_back(15'(iy - ct(it)));
        reqq.push_back("R10");
        @(posedge clk);
        @(negedge clk);
        chk("R9 ind_req", ind_req, 1);
        chk("R9 ind_addr", ind_addr, first);
        chk("R9 in_ready", in_ready, 0);
        // Offer a load while stalled: it must not be taken (R9).
        in_op = 2'b01; in_tag = 3'd1; in_load = 15'h7777;
        repeat (2) @(negedge clk);
        chk("R9 hold", ind_req, 1);
        in_valid = 1'b0;
        ind_valid = 1'b1; ind_y = iy; ind_tag = it;
        @(posedge clk);
        @(negedge clk);
        ind_valid = 1'b0;
        chk("R10 ind_req drop", ind_req, 0);
    endtask

    initial begin
        for (int i = 1; i <= 7; i++) mreg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 in_ready", in_ready, 1);
        chk("R1 ea_valid", ea_valid, 0);
        chk("R1 ind_req", ind_req, 0);
        issue(2'b00, 15'd321, 3'd7, 2'b00, 0, "R1");
        // R2 tag zero
        issue(2'b00, 15'd100, 3'd0, 2'b01, 0, "R2");
        // R5/R8 legacy single-bit loads
        issue(2'b01, 15'd11, 3'd1, 2'b11, 15'h0005, "R8");
        issue(2'b01, 15'd12, 3'd2, 2'b00, 15'h0030, "R8");
        issue(2'b01, 15'd13, 3'd4, 2'b00, 15'h0101, "R8");
        // R3 single bits
        issue(2'b00, 15'd1000, 3'd1, 2'b00, 0, "R3");
        issue(2'b00, 15'd1000, 3'd2, 2'b00, 0, "R3");
        issue(2'b00, 15'd1000, 3'd4, 2'b10, 0, "R3");
        // R4 OR of several
        issue(2'b00, 15'h4000, 3'd3, 2'b00, 0, "R4");
        issue(2'b00, 15'h4000, 3'd7, 2'b00, 0, "R4");
        // R5 multi-bit load writes regs 2 and 4
        issue(2'b01, 15'd20, 3'd6, 2'b00, 15'h0222, "R5");
        issue(2'b00, 15'h1000, 3'd2, 2'b00, 0, "R5");
        issue(2'b00, 15'h1000, 3'd4, 2'b00, 0, "R5");
        issue(2'b00, 15'h1000, 3'd1, 2'b00, 0, "R5");
        // R12 wrap
        issue(2'b00, 15'd2, 3'd1, 2'b00, 0, "R12");
        // R8 control op with indirect flag
        issue(2'b11, 15'd777, 3'd1, 2'b11, 0, "R8");
        // R9/R10 indirect in legacy mode
        indirect(15'd500, 3'd1, 15'h0400, 3'd2);
        issue(2'b00, 15'd50, 3'd1, 2'b00, 0, "R9");
        // R6 mode exit, then tag 3 names register 3 alone
        issue(2'b10, 15'd33, 3'd5, 2'b11, 0, "R6");
        issue(2'b00, 15'd900, 3'd3, 2'b00, 0, "R6");
        // R7 single-select loads
        issue(2'b01, 15'd1, 3'd3, 2'b00, 15'h0007, "R7");
        issue(2'b00, 15'd900, 3'd3, 2'b00, 0, "R7");
        issue(2'b01, 15'd2, 3'd0, 2'b00, 15'h0055, "R7");
        issue(2'b00, 15'd900, 3'd1, 2'b00, 0, "R7");
        issue(2'b00, 15'd900, 3'd0, 2'b00, 0, "R7");
        issue(2'b01, 15'd3, 3'd5, 2'b00, 15'h0011, "R7");
        issue(2'b01, 15'd4, 3'd6, 2'b00, 15'h0600, "R7");
        issue(2'b01, 15'd5, 3'd7, 2'b00, 15'h0013, "R7");
        issue(2'b00, 15'h2000, 3'd5, 2'b00, 0, "R7");
        issue(2'b00, 15'h2000, 3'd6, 2'b00, 0, "R6");
        issue(2'b00, 15'h2000, 3'd4, 2'b00, 0, "R7");
        // R6 mode persists across other instructions
        issue(2'b11, 15'd44, 3'd2, 2'b00, 0, "R8");
        issue(2'b00, 15'h0100, 3'd3, 2'b00, 0, "R6");
        // R10 indirect in single-select mode, different tags
        indirect(15'h0800, 3'd7, 15'h0050, 3'd6);
        issue(2'b00, 15'd10, 3'd7, 2'b00, 0, "R12");
        repeat (3) @(negedge clk);
        chk("R11 queue drained", expq.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule